// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits on the host side of an asynchronous parallel NOR flash that uses the unlock-cycle command protocol. A client issues one request per operation: reset, identifier read, word program, sector erase, chip erase or sector unlock. The sequencer expands the request into the required chain of bus writes to fixed unlock addresses. For program and erase requests, it then reads status bits back from the flash until the operation resolves.

Every bus access has the same whole-cycle shape. The first cycle is setup, with address and data driven and all strobes inactive. Next come `PULSE` cycles of active strobes. The access ends with one hold cycle. A request gets exactly one single-cycle response carrying a status code. For identifier reads, the response also carries the returned word. Failed program or erase operations, and polls that run out, are followed by an automatic reset sequence before the response.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are low and `nf_ce_n`, `nf_we_n` and `nf_oe_n` are all high.
- R2: A bus write drives address and data for one setup cycle with strobes high. It then holds `nf_ce_n` and `nf_we_n` low for exactly `PULSE` cycles, then keeps one hold cycle. `nf_we_n` and `nf_oe_n` are never low together, and the address does not change while `nf_ce_n` is low.
- R3: A bus read holds `nf_ce_n` and `nf_oe_n` low for exactly `PULSE` cycles. `nf_din` is sampled on the last of those cycles.
- R4: Request code 0 (reset) writes 0xAA to `UNLOCK_A` (default 0x05555), then 0x55 to `UNLOCK_B` (default 0x0AAAA), then 0xF0 to `UNLOCK_A`.
- R5: Request code 1 (identifier) writes the unlock pair and then 0x90 to `UNLOCK_A`. It then reads address 0 if `req_addr[0]` is 0 (maker code) or address 1 if it is 1 (device code). It exits with the unlock pair and 0xF0, and returns the word read on `rsp_data`.
- R6: Request code 2 (program) writes the unlock pair, then 0xA0 to `UNLOCK_A`, then `req_data` to `req_addr`. It then reads `req_addr` until bit 7 of the read word equals bit 7 of `req_data`, and reports status 0 (ok).
- R7: During a program poll, a mismatching read with bit 5 set triggers exactly one more read. If bit 7 still mismatches, the reset sequence of R4 follows and the status is 1 (write error).
- R8: Request code 3 (sector erase) writes the unlock pair, 0x80 to `UNLOCK_A`, the unlock pair again, and 0x30 to `req_addr`. It then polls `req_addr` until bit 7 reads 1. The bit-5 recheck works as in R7, but a failure reports status 2 (erase error).
- R9: Request code 4 (chip erase) writes the same first five words as R8, then 0x10 to `UNLOCK_A`, and polls address 0. If bit 3 is set in a read that is not complete, status 2 is reported at once with no reset sequence.
- R10: Request code 5 (sector unlock) writes 0xAA to `UNLOCK_A` and then 0x70 to `req_addr`. It performs no reads.
- R11: If `POLL_LIMIT` status reads pass without completion or a bit-5 recheck, the reset sequence follows and the status is 3 (timeout).
- R12: `busy` rises the cycle after a request is accepted and falls in the response cycle. Requests while busy, and request codes 6 and 7, are ignored and cause no bus activity. The bus is idle whenever `busy` is low.
- R13: `rsp_valid` is a one-cycle pulse per accepted request, with `rsp_status` valid during it. `rsp_data` is zero for every request code other than 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Request code (0..5) |
| req_addr | input | AW | Target word address or identifier select |
| req_data | input | DW | Word to program |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_status | output | 2 | 0 ok, 1 write error, 2 erase error, 3 timeout |
| rsp_data | output | DW | Identifier word |
| nf_addr | output | AW | Flash address |
| nf_dout | output | DW | Flash write data |
| nf_din | input | DW | Flash read data |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_we_n | output | 1 | Write enable, active low |
| nf_oe_n | output | 1 | Output enable, active low |

## Verification
The assertions check the following on every cycle:
- write and output enables never overlap;
- address and write data stay stable across an active strobe;
- chip enable is never low without a strobe;
- the bus is quiet while idle;
- the response is a single pulse that ends `busy`;
- invalid codes are ignored.

The bench scenarios cover the rest: the exact order and values of each command script, the number of status reads, and how DQ7, DQ5 and DQ3 readings map to completion, recheck, error and timeout. These are shown by feeding scripted status words from a flash model and comparing the captured write list and response against values built from the requirements.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    localparam int IDX_W = 4;

    typedef enum logic [2:0] {
        OP_RESET  = 3'd0,
        OP_IDENT  = 3'd1,
        OP_PROG   = 3'd2,
        OP_SERASE = 3'd3,
        OP_CERASE = 3'd4,
        OP_UNLOCK = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_WRERR   = 2'd1,
        ST_ERERR   = 2'd2,
        ST_TIMEOUT = 2'd3
    } stat_e;

    typedef enum logic [1:0] {
        SK_WRITE = 2'd0,
        SK_FETCH = 2'd1,
        SK_POLL  = 2'd2,
        SK_END   = 2'd3
    } step_e;

    typedef enum logic [2:0] {
        V_AGAIN,
        V_RECHECK,
        V_PASS,
        V_FAIL_RST,
        V_FAIL_NOW,
        V_TIMEOUT
    } verdict_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACT,
        PH_HOLD
    } phase_e;

    localparam logic [7:0] C_KEY1   = 8'hAA;
    localparam logic [7:0] C_KEY2   = 8'h55;
    localparam logic [7:0] C_EXIT   = 8'hF0;
    localparam logic [7:0] C_IDENT  = 8'h90;
    localparam logic [7:0] C_PROG   = 8'hA0;
    localparam logic [7:0] C_ERPREP = 8'h80;
    localparam logic [7:0] C_ERSEC  = 8'h30;
    localparam logic [7:0] C_ERALL  = 8'h10;
    localparam logic [7:0] C_UNLOCK = 8'h70;

endpackage

// File: rtl/nor_script.sv
module nor_script
    import nor_seq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16,
    parameter logic [AW-1:0] UNLOCK_A = AW'(20'h05555),
    parameter logic [AW-1:0] UNLOCK_B = AW'(20'h0AAAA)
) (
    input  op_e              op,
    input  logic [IDX_W-1:0] idx,
    input  logic [AW-1:0]    tgt_addr,
    input  logic [DW-1:0]    tgt_data,
    output step_e            kind,
    output logic [AW-1:0]    addr,
    output logic [DW-1:0]    data
);

    always_comb begin
        kind = SK_END;
        addr = '0;
        data = '0;
        if (op == OP_UNLOCK) begin
            case (idx)
                4'd0: begin kind = SK_WRITE; addr = UNLOCK_A; data = DW'(C_KEY1); end
                4'd1: begin kind = SK_WRITE; addr = tgt_addr; data = DW'(C_UNLOCK); end
                default: ;
            endcase
        end else if (idx == 4'd0) begin
            kind = SK_WRITE; addr = UNLOCK_A; data = DW'(C_KEY1);
        end else if (idx == 4'd1) begin
            kind = SK_WRITE; addr = UNLOCK_B; data = DW'(C_KEY2);
        end else begin
            case (op)
                OP_RESET: begin
                    if (idx == 4'd2) begin kind = SK_WRITE; addr = UNLOCK_A; data = DW'(C_EXIT); end
                end
                OP_IDENT: begin
                    case (idx)
                        4'd2: begin kind = SK_WRITE; addr = UNLOCK_A; data = DW'(C_IDENT); end
                        4'd3: begin kind = SK_FETCH; addr = AW'(tgt_addr[0]); end
                        4'd4: begin kind = SK_WRITE; addr = UNLOCK_A; data = DW'(C_KEY1); end
                        4'd5: begin kind = SK_WRITE; addr = UNLOCK_B; data = DW'(C_KEY2); end
                        4'd6: begin kind = SK_WRITE; addr = UNLOCK_A; data = DW'(C_EXIT); end
                        default: ;
                    endcase
                end
                OP_PROG: begin
                    case (idx)
                        4'd2: begin kind = SK_WRITE; addr = UNLOCK_A; data = DW'(C_PROG); end
                        4'd3: begin kind = SK_WRITE; addr = tgt_addr; data = tgt_data; end
                        4'd4: begin kind = SK_POLL;  addr = tgt_addr; end
                        default: ;
                    endcase
                end
                OP_SERASE, OP_CERASE: begin
                    case (idx)
                        4'd2: begin kind = SK_WRITE; addr = UNLOCK_A; data = DW'(C_ERPREP); end
                        4'd3: begin kind = SK_WRITE; addr = UNLOCK_A; data = DW'(C_KEY1); end
                        4'd4: begin kind = SK_WRITE; addr = UNLOCK_B; data = DW'(C_KEY2); end
                        4'd5: begin
                            kind = SK_WRITE;
                            addr = (op == OP_SERASE) ? tgt_addr : UNLOCK_A;
                            data = (op == OP_SERASE) ? DW'(C_ERSEC) : DW'(C_ERALL);
                        end
                        4'd6: begin
                            kind = SK_POLL;
                            addr = (op == OP_SERASE) ? tgt_addr : '0;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/nor_poll_judge.sv
module nor_poll_judge
    import nor_seq_pkg::*;
(
    input  op_e        op,
    input  logic [7:0] stat,
    input  logic       want7,
    input  logic       recheck,
    input  logic       at_limit,
    output verdict_e   verdict
);

    logic complete;

    always_comb begin
        complete = (op == OP_PROG) ? (stat[7] == want7) : stat[7];
        if (complete)                          verdict = V_PASS;
        else if (op == OP_CERASE && stat[3])   verdict = V_FAIL_NOW;
        else if (recheck)                      verdict = V_FAIL_RST;
        else if (stat[5])                      verdict = V_RECHECK;
        else if (at_limit)                     verdict = V_TIMEOUT;
        else                                   verdict = V_AGAIN;
    end

endmodule

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
    import nor_seq_pkg::*;
#(
    parameter int AW    = 20,
    parameter int DW    = 16,
    parameter int PULSE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_read,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          last,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] nf_addr,
    output logic [DW-1:0] nf_dout,
    input  logic [DW-1:0] nf_din,
    output logic          nf_ce_n,
    output logic          nf_we_n,
    output logic          nf_oe_n
);

    localparam int CW = $clog2(PULSE + 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] dout;
        logic [DW-1:0] rdata;
    } bus_t;

    bus_t q, d;

    always_comb begin
        d = q;
        unique case (q.phase)
            PH_IDLE: if (start) begin
                d.phase = PH_SETUP;
                d.rd    = is_read;
                d.addr  = addr;
                d.dout  = wdata;
            end
            PH_SETUP: begin
                d.phase = PH_ACT;
                d.cnt   = CW'(PULSE - 1);
            end
            PH_ACT: begin
                if (q.cnt == '0) begin
                    d.phase = PH_HOLD;
                    if (q.rd) d.rdata = nf_din;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_HOLD: d.phase = PH_IDLE;
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign last    = (q.phase == PH_HOLD);
    assign rdata   = q.rdata;
    assign nf_addr = q.addr;
    assign nf_dout = q.dout;
    assign nf_ce_n = (q.phase != PH_ACT);
    assign nf_we_n = !((q.phase == PH_ACT) && !q.rd);
    assign nf_oe_n = !((q.phase == PH_ACT) && q.rd);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int AW         = 20,
    parameter int DW         = 16,
    parameter int PULSE      = 2,
    parameter int POLL_LIMIT = 6,
    parameter logic [AW-1:0] UNLOCK_A = AW'(20'h05555),
    parameter logic [AW-1:0] UNLOCK_B = AW'(20'h0AAAA)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          busy,
    output logic          rsp_valid,
    output logic [1:0]    rsp_status,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] nf_addr,
    output logic [DW-1:0] nf_dout,
    input  logic [DW-1:0] nf_din,
    output logic          nf_ce_n,
    output logic          nf_we_n,
    output logic          nf_oe_n
);

    localparam int PCW = $clog2(POLL_LIMIT + 2);

    typedef struct packed {
        logic             busy;
        op_e              op;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
        logic [IDX_W-1:0] idx;
        logic             waiting;
        logic             recheck;
        logic [PCW-1:0]   pcnt;
        stat_e            status;
        logic             rsp_v;
        stat_e            rsp_st;
        logic [DW-1:0]    rsp_d;
        logic [DW-1:0]    id;
    } seq_t;

    seq_t q, d;

    step_e          sk_kind;
    logic [AW-1:0]  sk_addr;
    logic [DW-1:0]  sk_data;
    logic           bus_start;
    logic           bus_last;
    logic [DW-1:0]  bus_rdata;
    verdict_e       verdict;
    logic           at_limit;
    stat_e          fail_st;

    nor_script #(.AW(AW), .DW(DW), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)) u_script (
        .op(q.op), .idx(q.idx), .tgt_addr(q.addr), .tgt_data(q.data),
        .kind(sk_kind), .addr(sk_addr), .data(sk_data)
    );

    assign at_limit = ({1'b0, q.pcnt} + 1'b1) >= (PCW + 1)'(POLL_LIMIT);

    nor_poll_judge u_judge (
        .op(q.op), .stat(bus_rdata[7:0]), .want7(q.data[7]),
        .recheck(q.recheck), .at_limit(at_limit), .verdict(verdict)
    );

    nor_bus_cycle #(.AW(AW), .DW(DW), .PULSE(PULSE)) u_bus (
        .clk(clk), .rst_n(rst_n), .start(bus_start),
        .is_read(sk_kind != SK_WRITE), .addr(sk_addr), .wdata(sk_data),
        .last(bus_last), .rdata(bus_rdata),
        .nf_addr(nf_addr), .nf_dout(nf_dout), .nf_din(nf_din),
        .nf_ce_n(nf_ce_n), .nf_we_n(nf_we_n), .nf_oe_n(nf_oe_n)
    );

    assign fail_st = (q.op == OP_PROG) ? ST_WRERR : ST_ERERR;

    always_comb begin
        d         = q;
        d.rsp_v   = 1'b0;
        bus_start = 1'b0;
        if (!q.busy) begin
            if (req_valid && req_op <= 3'd5) begin
                d.busy    = 1'b1;
                d.op      = op_e'(req_op);
                d.addr    = req_addr;
                d.data    = req_data;
                d.idx     = '0;
                d.waiting = 1'b0;
                d.recheck = 1'b0;
                d.pcnt    = '0;
                d.status  = ST_OK;
                d.id      = '0;
            end
        end else if (!q.waiting) begin
            if (sk_kind == SK_END) begin
                d.busy   = 1'b0;
                d.rsp_v  = 1'b1;
                d.rsp_st = q.status;
                d.rsp_d  = q.id;
            end else begin
                bus_start = 1'b1;
                d.waiting = 1'b1;
            end
        end else if (bus_last) begin
            d.waiting = 1'b0;
            unique case (sk_kind)
                SK_WRITE: d.idx = q.idx + 1'b1;
                SK_FETCH: begin
                    d.id  = bus_rdata;
                    d.idx = q.idx + 1'b1;
                end
                SK_POLL: begin
                    d.pcnt = q.pcnt + 1'b1;
                    unique case (verdict)
                        V_PASS:     d.idx = q.idx + 1'b1;
                        V_RECHECK:  d.recheck = 1'b1;
                        V_FAIL_NOW: begin d.status = ST_ERERR; d.idx = q.idx + 1'b1; end
                        V_FAIL_RST: begin d.status = fail_st; d.op = OP_RESET; d.idx = '0; end
                        V_TIMEOUT:  begin d.status = ST_TIMEOUT; d.op = OP_RESET; d.idx = '0; end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy       = q.busy;
    assign rsp_valid  = q.rsp_v;
    assign rsp_status = q.rsp_st;
    assign rsp_data   = q.rsp_d;

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [2:0]    req_op,
    input logic          busy,
    input logic          rsp_valid,
    input logic [AW-1:0] nf_addr,
    input logic [DW-1:0] nf_dout,
    input logic          nf_ce_n,
    input logic          nf_we_n,
    input logic          nf_oe_n
);

    a_r2_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_oe_n));

    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_ce_n && $past(!nf_ce_n)) |-> $stable(nf_addr));

    a_r2_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n && $past(!nf_we_n)) |-> $stable(nf_dout));

    a_r3_ce_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_ce_n |-> (!nf_we_n || !nf_oe_n));

    a_r12_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nf_ce_n && nf_we_n && nf_oe_n));

    a_r12_bad_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_op > 3'd5) |=> !busy);

    a_r12_busy_ends_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rsp_valid);

    a_r13_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r13_rsp_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy);

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .busy(busy), .rsp_valid(rsp_valid), .nf_addr(nf_addr), .nf_dout(nf_dout),
    .nf_ce_n(nf_ce_n), .nf_we_n(nf_we_n), .nf_oe_n(nf_oe_n)
);

// File: tb/test_nor_cmd_seq.sv
`timescale 1ns/1ps
module test_nor_cmd_seq;

    localparam int AW = 20;
    localparam int DW = 16;
    localparam int PULSE = 2;
    localparam int LIM = 6;
    localparam logic [AW-1:0] UA = 20'h05555;
    localparam logic [AW-1:0] UB = 20'h0AAAA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          busy, rsp_valid;
    logic [1:0]    rsp_status;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] nf_addr;
    logic [DW-1:0] nf_dout;
    logic [DW-1:0] nf_din = 16'hDEAD;
    logic          nf_ce_n, nf_we_n, nf_oe_n;

    always #2.5 clk = ~clk;

    nor_cmd_seq #(.AW(AW), .DW(DW), .PULSE(PULSE), .POLL_LIMIT(LIM)) i_nor_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_data(rsp_data), .nf_addr(nf_addr),
        .nf_dout(nf_dout), .nf_din(nf_din), .nf_ce_n(nf_ce_n),
        .nf_we_n(nf_we_n), .nf_oe_n(nf_oe_n)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [AW+DW-1:0] wr_seen[$];
    logic [AW+DW-1:0] wr_exp[$];
    logic [AW-1:0]    rd_addr[$];
    logic [DW-1:0]    rd_feed[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Reference flash model and per-clock bus monitor
    logic          p_we_n = 1'b1, p_oe_n = 1'b1;
    logic [AW-1:0] p_addr = '0;
    int            we_run = 0, oe_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(nf_ce_n == (nf_we_n & nf_oe_n), "R2 ce follows strobes", nf_ce_n, nf_we_n & nf_oe_n);
            if (!nf_we_n && p_we_n) begin
                wr_seen.push_back({nf_addr, nf_dout});
                chk(nf_addr == p_addr, "R2 address set up before strobe", nf_addr, p_addr);
            end
            if (!nf_oe_n && p_oe_n) rd_addr.push_back(nf_addr);
            if (!nf_we_n) we_run++;
            else if (!p_we_n) begin
                chk(we_run == PULSE, "R2 write strobe length", we_run, PULSE);
                we_run = 0;
            end
            if (!nf_oe_n) oe_run++;
            else if (!p_oe_n) begin
                chk(oe_run == PULSE, "R3 read strobe length", oe_run, PULSE);
                oe_run = 0;
                if (rd_feed.size() > 0) void'(rd_feed.pop_front());
            end
        end
        p_we_n = nf_we_n;
        p_oe_n = nf_oe_n;
        p_addr = nf_addr;
        nf_din = (rd_feed.size() > 0) ? rd_feed[0] : 16'hDEAD;
    end

    task automatic ew(input logic [AW-1:0] a, input logic [DW-1:0] dv);
        wr_exp.push_back({a, dv});
    endtask

    task automatic unlock_pair();
        ew(UA, 16'h00AA);
        ew(UB, 16'h0055);
    endtask

    task automatic reset_seq();
        unlock_pair();
        ew(UA, 16'h00F0);
    endtask

    bit dog = 0;

    task automatic run(input string tag, input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] dv, input logic [1:0] exp_st,
                       input logic [DW-1:0] exp_data, input int exp_rd,
                       input logic [AW-1:0] exp_rd_addr, input bit poke);
        int cyc;
        wr_seen.delete();
        rd_addr.delete();
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = dv;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, {tag, " busy after accept"}, busy, 1);
        cyc = 0;
        while (!rsp_valid && cyc < 3000) begin
            if (poke && cyc == 3) begin
                req_valid = 1'b1; req_op = 3'd2; req_addr = 20'h00777; req_data = 16'h1111;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        if (!rsp_valid) begin
            dog = 1;
            chk(0, {tag, " watchdog"}, cyc, 0);
            return;
        end
        chk(rsp_status == exp_st, {tag, " status"}, rsp_status, exp_st);
        chk(rsp_data == exp_data, {tag, " R13 response data"}, rsp_data, exp_data);
        chk(!busy, {tag, " R12 busy low at response"}, busy, 0);
        chk(wr_seen.size() == wr_exp.size(), {tag, " write count"}, wr_seen.size(), wr_exp.size());
        foreach (wr_exp[i])
            if (i < wr_seen.size())
                chk(wr_seen[i] == wr_exp[i], {tag, " write entry"}, wr_seen[i], wr_exp[i]);
        chk(rd_addr.size() == exp_rd, {tag, " read count"}, rd_addr.size(), exp_rd);
        foreach (rd_addr[i])
            chk(rd_addr[i] == exp_rd_addr, {tag, " read address"}, rd_addr[i], exp_rd_addr);
        @(negedge clk);
        chk(!rsp_valid, {tag, " R13 single response pulse"}, rsp_valid, 0);
        chk(!busy, {tag, " R12 stays idle"}, busy, 0);
        wr_exp.delete();
        rd_feed.delete();
    endtask

    initial begin
        #(5.0 * 150000);
        dog = 1;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !rsp_valid, "R1 idle outputs in reset", {busy, rsp_valid}, 0);
        chk(nf_ce_n && nf_we_n && nf_oe_n, "R1 strobes high in reset", {nf_ce_n, nf_we_n, nf_oe_n}, 3'b111);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && nf_ce_n && nf_we_n && nf_oe_n, "R1 idle after reset", {busy, nf_ce_n}, 2'b01);

        // R4 reset sequence
        reset_seq();
        run("R4 reset", 3'd0, 20'h0, 16'h0, 2'd0, 16'h0, 0, 20'h0, 0);

        // R5 identifier reads
        unlock_pair(); ew(UA, 16'h0090); reset_seq();
        rd_feed.push_back(16'h0001);
        run("R5 maker code", 3'd1, 20'h0, 16'h0, 2'd0, 16'h0001, 1, 20'h0, 0);
        unlock_pair(); ew(UA, 16'h0090); reset_seq();
        rd_feed.push_back(16'h22D7);
        run("R5 device code", 3'd1, 20'h1, 16'h0, 2'd0, 16'h22D7, 1, 20'h1, 0);

        // R6 program, completion on second read (R3 sampling)
        unlock_pair(); ew(UA, 16'h00A0); ew(20'h00100, 16'h1234);
        rd_feed.push_back(16'h0080); rd_feed.push_back(16'h0034);
        run("R6 program", 3'd2, 20'h00100, 16'h1234, 2'd0, 16'h0, 2, 20'h00100, 0);

        // R7 recheck passes
        unlock_pair(); ew(UA, 16'h00A0); ew(20'h00200, 16'h00FF);
        rd_feed.push_back(16'h007F); rd_feed.push_back(16'h00FF);
        run("R7 recheck pass", 3'd2, 20'h00200, 16'h00FF, 2'd0, 16'h0, 2, 20'h00200, 0);

        // R7 recheck fails: write error with reset
        unlock_pair(); ew(UA, 16'h00A0); ew(20'h00300, 16'h0080); reset_seq();
        rd_feed.push_back(16'h0020); rd_feed.push_back(16'h0000);
        run("R7 write error", 3'd2, 20'h00300, 16'h0080, 2'd1, 16'h0, 2, 20'h00300, 0);

        // R8 sector erase
        unlock_pair(); ew(UA, 16'h0080); unlock_pair(); ew(20'h30000, 16'h0030);
        rd_feed.push_back(16'h0000); rd_feed.push_back(16'h0080);
        run("R8 sector erase", 3'd3, 20'h30000, 16'h0, 2'd0, 16'h0, 2, 20'h30000, 0);
        unlock_pair(); ew(UA, 16'h0080); unlock_pair(); ew(20'h40000, 16'h0030); reset_seq();
        rd_feed.push_back(16'h0020); rd_feed.push_back(16'h0020);
        run("R8 erase error", 3'd3, 20'h40000, 16'h0, 2'd2, 16'h0, 2, 20'h40000, 0);

        // R9 chip erase
        unlock_pair(); ew(UA, 16'h0080); unlock_pair(); ew(UA, 16'h0010);
        rd_feed.push_back(16'h0000); rd_feed.push_back(16'h0080);
        run("R9 chip erase", 3'd4, 20'h12345, 16'h0, 2'd0, 16'h0, 2, 20'h0, 0);
        unlock_pair(); ew(UA, 16'h0080); unlock_pair(); ew(UA, 16'h0010);
        rd_feed.push_back(16'h0008);
        run("R9 bit3 error", 3'd4, 20'h0, 16'h0, 2'd2, 16'h0, 1, 20'h0, 0);

        // R10 sector unlock
        ew(UA, 16'h00AA); ew(20'h12000, 16'h0070);
        run("R10 unlock", 3'd5, 20'h12000, 16'h0, 2'd0, 16'h0, 0, 20'h0, 0);

        // R11 poll limit
        unlock_pair(); ew(UA, 16'h00A0); ew(20'h00400, 16'h0000); reset_seq();
        for (int i = 0; i < LIM; i++) rd_feed.push_back(16'h0080);
        run("R11 timeout", 3'd2, 20'h00400, 16'h0000, 2'd3, 16'h0, LIM, 20'h00400, 0);

        // R12 request while busy ignored
        ew(UA, 16'h00AA); ew(20'h05000, 16'h0070);
        run("R12 busy ignore", 3'd5, 20'h05000, 16'h0, 2'd0, 16'h0, 0, 20'h0, 1);
        repeat (20) @(negedge clk);
        chk(!busy && wr_seen.size() == 2, "R12 no late request", wr_seen.size(), 2);

        // R12 invalid codes
        wr_seen.delete();
        for (int c = 6; c < 8; c++) begin
            @(negedge clk);
            req_valid = 1'b1; req_op = 3'(c);
            @(negedge clk);
            req_valid = 1'b0;
            repeat (8) @(negedge clk);
            chk(!busy && wr_seen.size() == 0, "R12 invalid code ignored", {busy, 8'(wr_seen.size())}, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule